// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block sits between a set of external interrupt pins and a downstream interrupt controller. Each of its input lines is brought into the clock domain through a two-flop synchroniser. It is then sensed as a level or an edge, with a polarity of its own. A detected request is held in a per-line sticky latch. The latched requests pass through a per-line mask and leave the block as active-high level outputs. The controller therefore always sees a high level, whatever sense the pin uses.

Software configures and services the block through a single-cycle register port. The port has a word index, a write enable, write data and combinational read data. Bit i of every register belongs to line i. A latched request stays set until software clears it with a write-one-to-clear access. A request can be latched while its line is masked, so software should clear a line before unmasking it. A separate register lets software raise a request on any line.

Top module: `ext_irq_sense`

## Requirements
- R1: After a synchronous reset, the block-register (word index 0) reads all ones. Every latched request, the polarity register and the sense-mode register read zero, and every output is low.
- R2: The register word indices are fixed. Index 0 is the block register (1 = line blocked). Index 1 is a spare select register with no effect on sensing. Index 2 is masked status and index 3 is raw status. Index 4 is clear, index 5 is polarity (1 = high or rising), index 6 is sense mode (1 = edge) and index 7 is software request. Indices 0, 1, 5 and 6 read back the value last written. Indices 4 and 7 read as zero.
- R3: A change on an input reaches the raw status and the outputs after exactly three rising clock edges: two synchroniser stages, then the latch.
- R4: In edge mode, only the edge selected by the polarity bit (rising for 1, falling for 0) sets the latch. The opposite edge does not. A clear takes effect even while the input stays at its new level.
- R5: In level mode, the latch sets while the input is at its active level (high for polarity 1, low for polarity 0). It stays set after the level goes away, and a clear has no effect while the level is still active.
- R6: Writing 1 to a bit of the clear register (index 4) clears that line's latch. Writing 0 to a bit leaves it unchanged.
- R7: Masked status (index 2) and the outputs equal raw status ANDed with the inverse of the block register. Raw status (index 3) does not depend on the block register.
- R8: A request latched while its line is blocked is kept. It appears on the output as soon as the line is unblocked, without a new input event.
- R9: When a clear write and a new active edge hit the same line in the same cycle, the latch stays set.
- R10: Writing 1 to a bit of the software request register (index 7) sets that line's latch on the write edge. Writing 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_we | input | 1 | Write enable, one access per cycle |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Combinational read data for bus_addr |
| irq_in | input | NUM_LINES | Asynchronous external interrupt lines |
| irq_out | output | NUM_LINES | Active-high level requests to the controller |

## Verification
Two things can touch the same latch in one cycle: a clear write from software and a freshly synchronised rising edge on that line. The bench raises the input on a falling clock edge. It then waits two cycles, so the write to the clear register lands on the same rising edge that the edge detector fires. The latch must still read set afterwards. A clear written one cycle later, while the input is still high, must empty it, which shows that the same-cycle result comes from precedence and not from a lost write.

// File: rtl/eis_pkg.sv
package eis_pkg;

    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_BLOCK = 3'd0,
        REG_SPARE = 3'd1,
        REG_MSTAT = 3'd2,
        REG_RAW   = 3'd3,
        REG_CLEAR = 3'd4,
        REG_POL   = 3'd5,
        REG_MODE  = 3'd6,
        REG_SWSET = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic edge_mode;
        logic act_high;
    } sense_cfg_t;

    // Returns 1 when the line presents a request in this cycle.
    function automatic logic sense_hit(sense_cfg_t cfg, logic cur, logic prev);
        logic act_now;
        logic act_before;
        act_now    = cfg.act_high ? cur  : ~cur;
        act_before = cfg.act_high ? prev : ~prev;
        return cfg.edge_mode ? (act_now & ~act_before) : act_now;
    endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic [WIDTH-1:0] sync_prev
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;
    logic [WIDTH-1:0] stage3;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            stage3 <= '0;
        end else begin
            stage1 <= async_in;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    assign sync_out  = stage2;
    assign sync_prev = stage3;

endmodule

// File: rtl/eis_line.sv
module eis_line
    import eis_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sense_cfg_t cfg,
    input  logic       cur,
    input  logic       prev,
    input  logic       clr,
    input  logic       sw_set,
    output logic       req
);

    logic set_now;

    assign set_now = sense_hit(cfg, cur, prev) | sw_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else begin
            req <= set_now | (req & ~clr);
        end
    end

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_now) |=> !req);

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        set_now |=> req);

    assert_request_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (req && !clr) |=> req);

endmodule

// File: rtl/eis_regs.sv
module eis_regs
    import eis_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [REG_IDX_W-1:0] addr,
    input  logic                 we,
    input  logic [NUM_LINES-1:0] wdata,
    input  logic [NUM_LINES-1:0] raw,
    output logic [NUM_LINES-1:0] rdata,
    output logic [NUM_LINES-1:0] block_q,
    output logic [NUM_LINES-1:0] pol_q,
    output logic [NUM_LINES-1:0] mode_q,
    output logic [NUM_LINES-1:0] clr_pulse,
    output logic [NUM_LINES-1:0] sw_pulse
);

    logic [NUM_LINES-1:0] spare_q;
    reg_idx_e             idx;

    assign idx = reg_idx_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            block_q <= '1;
            spare_q <= '0;
            pol_q   <= '0;
            mode_q  <= '0;
        end else if (we) begin
            case (idx)
                REG_BLOCK: block_q <= wdata;
                REG_SPARE: spare_q <= wdata;
                REG_POL:   pol_q   <= wdata;
                REG_MODE:  mode_q  <= wdata;
                default:   ;
            endcase
        end
    end

    assign clr_pulse = (we && idx == REG_CLEAR) ? wdata : '0;
    assign sw_pulse  = (we && idx == REG_SWSET) ? wdata : '0;

    always_comb begin
        case (idx)
            REG_BLOCK: rdata = block_q;
            REG_SPARE: rdata = spare_q;
            REG_MSTAT: rdata = raw & ~block_q;
            REG_RAW:   rdata = raw;
            REG_POL:   rdata = pol_q;
            REG_MODE:  rdata = mode_q;
            default:   rdata = '0;
        endcase
    end

    assert_block_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && idx == REG_BLOCK) |=> block_q == $past(wdata));

    assert_reset_blocked_R1: assert property (@(posedge clk)
        rst |=> (block_q == '1 && pol_q == '0 && mode_q == '0));

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import eis_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [REG_IDX_W-1:0] bus_addr,
    input  logic                 bus_we,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out
);

    logic [NUM_LINES-1:0] sync_cur;
    logic [NUM_LINES-1:0] sync_prev;
    logic [NUM_LINES-1:0] raw_req;
    logic [NUM_LINES-1:0] block_q;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] clr_pulse;
    logic [NUM_LINES-1:0] sw_pulse;

    eis_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .async_in  (irq_in),
        .sync_out  (sync_cur),
        .sync_prev (sync_prev)
    );

    eis_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .raw       (raw_req),
        .rdata     (bus_rdata),
        .block_q   (block_q),
        .pol_q     (pol_q),
        .mode_q    (mode_q),
        .clr_pulse (clr_pulse),
        .sw_pulse  (sw_pulse)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        sense_cfg_t cfg;
        assign cfg.edge_mode = mode_q[i];
        assign cfg.act_high  = pol_q[i];

        eis_line u_line (
            .clk    (clk),
            .rst    (rst),
            .cfg    (cfg),
            .cur    (sync_cur[i]),
            .prev   (sync_prev[i]),
            .clr    (clr_pulse[i]),
            .sw_set (sw_pulse[i]),
            .req    (raw_req[i])
        );
    end

    assign irq_out = raw_req & ~block_q;

    assert_blocked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_out & block_q) == '0);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (raw_req == '0 && irq_out == '0));

endmodule

// File: tb/ext_irq_sense_bench.sv
module ext_irq_sense_bench;
    import eis_pkg::*;

    localparam int N = 32;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [REG_IDX_W-1:0] bus_addr = '0;
    logic                 bus_we = 1'b0;
    logic [N-1:0]         bus_wdata = '0;
    logic [N-1:0]         bus_rdata;
    logic [N-1:0]         irq_in = '0;
    logic [N-1:0]         irq_out;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] pol_v;
    logic [N-1:0] mode_v;

    always #5 clk = ~clk;

    ext_irq_sense #(.NUM_LINES(N)) u_ext_irq_sense (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .irq_out   (irq_out)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input reg_idx_e idx, input logic [N-1:0] data);
        bus_addr  = idx;
        bus_wdata = data;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input reg_idx_e idx, output logic [N-1:0] data);
        bus_addr = idx;
        #1;
        data = bus_rdata;
    endtask

    task automatic t_reset;
        logic [N-1:0] v;
        rd(REG_BLOCK, v); check("R1 block reset", v, '1);
        rd(REG_RAW, v);   check("R1 raw reset", v, '0);
        rd(REG_POL, v);   check("R1 pol reset", v, '0);
        rd(REG_MODE, v);  check("R1 mode reset", v, '0);
        check("R1 outputs reset", irq_out, '0);
    endtask

    task automatic t_setup;
        logic [N-1:0] v;
        irq_in = 32'h0000_0050;
        pol_v  = ~32'h0000_0050;
        mode_v = 32'h0000_0060;
        wr(REG_POL, pol_v);
        wr(REG_MODE, mode_v);
        step(4);
        wr(REG_CLEAR, '1);
        rd(REG_RAW, v); check("R6 clear all", v, '0);
    endtask

    task automatic t_regmap;
        logic [N-1:0] v;
        wr(REG_BLOCK, 32'hA5A5_0F0F);
        rd(REG_BLOCK, v); check("R2 block readback", v, 32'hA5A5_0F0F);
        wr(REG_SPARE, 32'h1234_5678);
        rd(REG_SPARE, v); check("R2 spare readback", v, 32'h1234_5678);
        rd(REG_POL, v);   check("R2 pol readback", v, pol_v);
        rd(REG_MODE, v);  check("R2 mode readback", v, mode_v);
        rd(REG_CLEAR, v); check("R2 clear reads zero", v, '0);
        rd(REG_SWSET, v); check("R2 swset reads zero", v, '0);
        rd(REG_RAW, v);   check("R2 spare has no effect", v, '0);
        wr(REG_BLOCK, '1);
    endtask

    task automatic t_level_high;
        logic [N-1:0] v;
        wr(REG_BLOCK, ~32'h8);
        irq_in[3] = 1'b1;
        step(2);
        rd(REG_RAW, v); check("R3 not yet after two edges", N'(v[3]), '0);
        step(1);
        rd(REG_RAW, v); check("R3 latched after three edges", N'(v[3]), N'(1));
        check("R5 level high drives output", N'(irq_out[3]), N'(1));
        wr(REG_CLEAR, 32'h8);
        rd(REG_RAW, v); check("R5 clear ignored while active", N'(v[3]), N'(1));
        irq_in[3] = 1'b0;
        step(3);
        rd(REG_RAW, v); check("R5 sticky after level drops", N'(v[3]), N'(1));
        wr(REG_CLEAR, 32'h8);
        rd(REG_RAW, v); check("R6 clear after level drops", N'(v[3]), '0);
        wr(REG_BLOCK, '1);
    endtask

    task automatic t_level_low;
        logic [N-1:0] v;
        rd(REG_RAW, v); check("R5 low line idle while high", N'(v[4]), '0);
        irq_in[4] = 1'b0;
        step(3);
        rd(REG_RAW, v); check("R5 level low latches", N'(v[4]), N'(1));
        irq_in[4] = 1'b1;
        step(3);
        wr(REG_CLEAR, 32'h10);
        rd(REG_RAW, v); check("R6 clear low line", N'(v[4]), '0);
    endtask

    task automatic t_edges;
        logic [N-1:0] v;
        irq_in[5] = 1'b1;
        step(3);
        rd(REG_RAW, v); check("R4 rising edge latches", N'(v[5]), N'(1));
        wr(REG_CLEAR, 32'h20);
        rd(REG_RAW, v); check("R4 clear while input held high", N'(v[5]), '0);
        irq_in[5] = 1'b0;
        step(3);
        rd(REG_RAW, v); check("R4 falling edge ignored on rising line", N'(v[5]), '0);
        irq_in[6] = 1'b0;
        step(3);
        rd(REG_RAW, v); check("R4 falling edge latches", N'(v[6]), N'(1));
        wr(REG_CLEAR, 32'h40);
        irq_in[6] = 1'b1;
        step(3);
        rd(REG_RAW, v); check("R4 rising edge ignored on falling line", N'(v[6]), '0);
    endtask

    task automatic t_collision;
        logic [N-1:0] v;
        irq_in[5] = 1'b1;
        step(2);
        wr(REG_CLEAR, 32'h20);
        rd(REG_RAW, v); check("R9 edge beats same-cycle clear", N'(v[5]), N'(1));
        wr(REG_CLEAR, 32'h20);
        rd(REG_RAW, v); check("R9 later clear empties", N'(v[5]), '0);
        irq_in[5] = 1'b0;
        step(3);
    endtask

    task automatic t_soft_and_mask;
        logic [N-1:0] v;
        wr(REG_SWSET, '0);
        rd(REG_RAW, v); check("R10 zero write no effect", v & 32'h0000_0180, '0);
        wr(REG_SWSET, 32'h80);
        rd(REG_RAW, v);   check("R10 software set", N'(v[7]), N'(1));
        check("R8 blocked line output low", N'(irq_out[7]), '0);
        rd(REG_MSTAT, v); check("R7 masked status hides blocked", N'(v[7]), '0);
        wr(REG_CLEAR, ~32'h80);
        rd(REG_RAW, v);   check("R6 zero bit keeps latch", N'(v[7]), N'(1));
        wr(REG_BLOCK, ~32'h80);
        check("R8 stale request on unblock", N'(irq_out[7]), N'(1));
        rd(REG_MSTAT, v); check("R7 masked status shows unblocked", N'(v[7]), N'(1));
        rd(REG_RAW, v);   check("R7 raw independent of block", N'(v[7]), N'(1));
        wr(REG_CLEAR, 32'h80);
        check("R6 output drops after clear", N'(irq_out[7]), '0);
        wr(REG_BLOCK, '1);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        t_reset();
        t_setup();
        t_regmap();
        t_level_high();
        t_level_low();
        t_edges();
        t_collision();
        t_soft_and_mask();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule